// File: doc/BRIEF.md
# SPI Event Flags and Interrupt Request

This block collects the status strobes of a serial peripheral interface and turns them into sticky event flags in an 8-bit register. The flags record a multi-master collision, a transmit error, a received character thrown away for lack of a buffer, a completed transmit buffer and a closed receive buffer. Software reads the flags through a small register bus and clears them by writing ones. A second register of the same layout enables each flag's contribution to a single level interrupt request.

Register bits are numbered with bit 0 as the most significant bit. On the data bus, register bit n is carried on `reg_wdata`/`reg_rdata` line 7-n. The flag positions are:
- Register bit 2 (data line 5): collision. The slave select became active while the interface was master.
- Register bit 3 (data line 4): transmit error.
- Register bit 5 (data line 2): receive overrun. A character arrived with no buffer free.
- Register bit 6 (data line 1): transmit buffer done.
- Register bit 7 (data line 0): receive buffer done.

Register bits 0, 1 and 4 (data lines 7, 6 and 3) are reserved.

There are two small state machines.

The select watcher has two states, `SEL_IDLE` and `SEL_HELD`:
- It goes from `SEL_IDLE` to `SEL_HELD` when `ss_active` is high.
- It goes from `SEL_HELD` to `SEL_IDLE` when `ss_active` is low.
- A collision is flagged only on the `SEL_IDLE` to `SEL_HELD` move, and only while `master_mode` is high.

The request sequencer has two states, `IRQ_QUIET` and `IRQ_RAISED`:
- It moves to `IRQ_RAISED` when any enabled flag is pending.
- It moves back to `IRQ_QUIET` once no enabled flag is pending.
- Its state is the `irq` output.

Top module: `spi_evt_ctrl`

## Requirements
- R1: After reset, the event register reads 0x00, the enable register reads 0x00, and `irq` is low.
- R2: Data lines 7, 6 and 3 read 0 in both registers. Writing ones to these lines changes nothing that can be read and does not raise `irq`.
- R3: A write with `reg_addr`=0 clears every flag whose data line is 1. Several flags can be cleared in one write. Flags written with 0 keep their value.
- R4: If a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R5: Line 5 sets on the clock edge that sees `ss_active` rise (low in the previous cycle) while `master_mode` is high. A select held high does not set the flag again after it is cleared. A rise while `master_mode` is low does not set it.
- R6: Line 2 sets on an edge where `rx_char_stb` is high and `rx_buf_free` is low. A character with a free buffer does not set it.
- R7: Line 4 sets on an edge where `tx_err_stb` is high.
- R8: Line 1 sets on an edge where `tx_buf_done_stb` is high.
- R9: Line 0 sets on an edge where `rx_buf_closed_stb` is high.
- R10: A write with `reg_addr`=1 loads the enable register. `reg_rdata` returns the enable register when `reg_addr`=1 and the event register when `reg_addr`=0, combinationally and at any time. A write takes effect only when `reg_sel` and `reg_wr` are both high.
- R11: `irq` is registered. In each cycle it equals the OR of (event AND enable) as it stood in the previous cycle. It therefore stays high until every enabled pending flag is cleared or disabled, and pending flags that are disabled never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ss_active | input | 1 | External slave select sensed active (high = asserted) |
| master_mode | input | 1 | Interface is operating as master |
| rx_char_stb | input | 1 | One-cycle pulse: a character was received |
| rx_buf_free | input | 1 | A receive buffer is available for that character |
| tx_err_stb | input | 1 | One-cycle pulse: transmit error |
| tx_buf_done_stb | input | 1 | One-cycle pulse: last character of a transmit buffer went into the FIFO |
| rx_buf_closed_stb | input | 1 | One-cycle pulse: receive buffer filled and closed |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Register bus write |
| reg_addr | input | 1 | 0 = event register, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives a hardware set and a write-one-to-clear of the same flag in one cycle. A design that lets the clear win loses the event and reads 0 where 1 is expected. It holds the select high across a clear and also raises it while in slave mode. A level-sensitive or mode-blind collision detector would therefore set line 5 again or set it wrongly. It enables only some flags and clears the enabled one while a disabled flag stays pending. An OR over all flags would keep `irq` high, and a request that is not registered would move a cycle early. Writes of ones to the reserved lines and writes with zeros show whether reserved storage leaks into reads or whether a zero write clears anything.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int REG_W   = 8;
    // data-line index of each flag (register bit n sits on line REG_W-1-n)
    localparam int EVT_MME = 5;
    localparam int EVT_TXE = 4;
    localparam int EVT_BSY = 2;
    localparam int EVT_TXB = 1;
    localparam int EVT_RXB = 0;
    localparam logic [REG_W-1:0] EVT_VALID =
        (REG_W'(1) << EVT_MME) | (REG_W'(1) << EVT_TXE) | (REG_W'(1) << EVT_BSY) |
        (REG_W'(1) << EVT_TXB) | (REG_W'(1) << EVT_RXB);

    typedef enum logic [0:0] {SEL_IDLE = 1'b0, SEL_HELD = 1'b1} sel_state_e;
    typedef enum logic [0:0] {IRQ_QUIET = 1'b0, IRQ_RAISED = 1'b1} irq_state_e;
endpackage

// File: rtl/spi_evt_collide.sv
module spi_evt_collide
    import spi_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_in,
    input  logic master,
    output logic collide
);
    sel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        collide = 1'b0;
        unique case (state_q)
            SEL_IDLE: begin
                if (sel_in) begin
                    state_d = SEL_HELD;
                    collide = master;
                end
            end
            SEL_HELD: begin
                if (!sel_in) state_d = SEL_IDLE;
            end
            default: state_d = SEL_IDLE;
        endcase
    end
endmodule

// File: rtl/spi_evt_sticky.sv
module spi_evt_sticky #(
    parameter int               W     = 8,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          bit_q <= 1'b0;
                else if (set_vec[i]) bit_q <= 1'b1;  // set has priority
                else if (clr_vec[i]) bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = set_vec[i] | clr_vec[i];
            assign q[i] = 1'b0 & unused_in;
        end
    end
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
    import spi_evt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    output logic         irq
);
    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = |(evt & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
    import spi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_active,
    input  logic             master_mode,
    input  logic             rx_char_stb,
    input  logic             rx_buf_free,
    input  logic             tx_err_stb,
    input  logic             tx_buf_done_stb,
    input  logic             rx_buf_closed_stb,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic             collide;
    logic [REG_W-1:0] set_vec, clr_vec, evt_q, en_q, en_set, en_clr;
    logic             wr_evt, wr_en;

    assign wr_evt = reg_sel && reg_wr && !reg_addr;
    assign wr_en  = reg_sel && reg_wr &&  reg_addr;

    spi_evt_collide u_collide (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (ss_active),
        .master  (master_mode),
        .collide (collide)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[EVT_MME] = collide;
        set_vec[EVT_TXE] = tx_err_stb;
        set_vec[EVT_BSY] = rx_char_stb && !rx_buf_free;
        set_vec[EVT_TXB] = tx_buf_done_stb;
        set_vec[EVT_RXB] = rx_buf_closed_stb;
        clr_vec          = wr_evt ? reg_wdata : '0;
        en_set           = wr_en ? reg_wdata  : '0;
        en_clr           = wr_en ? ~reg_wdata : '0;
    end

    spi_evt_sticky #(.W(REG_W), .VALID(EVT_VALID)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (evt_q)
    );

    spi_evt_sticky #(.W(REG_W), .VALID(EVT_VALID)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (en_set),
        .clr_vec (en_clr),
        .q       (en_q)
    );

    spi_evt_irq #(.W(REG_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_q),
        .en    (en_q),
        .irq   (irq)
    );

    assign reg_rdata = reg_addr ? en_q : evt_q;
endmodule

// File: rtl/spi_evt_chk.sv
module spi_evt_chk
    import spi_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ss_active,
    input logic             master_mode,
    input logic             rx_char_stb,
    input logic             rx_buf_free,
    input logic             tx_err_stb,
    input logic             tx_buf_done_stb,
    input logic             rx_buf_closed_stb,
    input logic             reg_sel,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] evt,
    input logic [REG_W-1:0] en,
    input logic             irq
);
    logic [REG_W-1:0] clr_req;
    assign clr_req = (reg_sel && reg_wr && !reg_addr) ? reg_wdata : '0;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt | en) & ~EVT_VALID) == '0);
    // R3
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(evt) & ~$past(clr_req)) & ~evt) == '0));
    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_buf_done_stb |=> evt[EVT_TXB]);
    // R5
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active && !$past(ss_active) && master_mode) |=> evt[EVT_MME]);
    // R6
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_stb && !rx_buf_free) |=> evt[EVT_BSY]);
    // R7
    tx_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_stb |=> evt[EVT_TXE]);
    // R9
    rx_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_closed_stb |=> evt[EVT_RXB]);
    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & en)) |=> irq);
    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(evt & en)) |=> !irq);
endmodule

bind spi_evt_ctrl spi_evt_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .ss_active         (ss_active),
    .master_mode       (master_mode),
    .rx_char_stb       (rx_char_stb),
    .rx_buf_free       (rx_buf_free),
    .tx_err_stb        (tx_err_stb),
    .tx_buf_done_stb   (tx_buf_done_stb),
    .rx_buf_closed_stb (rx_buf_closed_stb),
    .reg_sel           (reg_sel),
    .reg_wr            (reg_wr),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .evt               (evt_q),
    .en                (en_q),
    .irq               (irq)
);

// File: tb/spi_evt_ctrl_tb.sv
module spi_evt_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_active = 0, master_mode = 0, rx_char_stb = 0, rx_buf_free = 0;
    logic       tx_err_stb = 0, tx_buf_done_stb = 0, rx_buf_closed_stb = 0;
    logic       reg_sel = 0, reg_wr = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq;

    int vectors = 0;
    int misses  = 0;

    // behavioural reference state
    logic [7:0] m_evt = 0, m_en = 0;
    logic       m_irq = 0, m_sel_prev = 0;

    always #10 clk = ~clk;

    spi_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ss_active(ss_active), .master_mode(master_mode),
        .rx_char_stb(rx_char_stb), .rx_buf_free(rx_buf_free), .tx_err_stb(tx_err_stb),
        .tx_buf_done_stb(tx_buf_done_stb), .rx_buf_closed_stb(rx_buf_closed_stb),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #2000000;
        misses++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    // one bus/strobe cycle: drive, compare current state, advance model at the edge
    task automatic cyc(input logic ss, input logic mm, input logic rxc, input logic rxf,
                       input logic txe, input logic txb, input logic rxb,
                       input logic wr, input logic adr, input logic [7:0] wd,
                       input string tag);
        logic [7:0] exp_rd, set_m, clr_m, n_evt, n_en;
        logic       n_irq;
        ss_active = ss; master_mode = mm; rx_char_stb = rxc; rx_buf_free = rxf;
        tx_err_stb = txe; tx_buf_done_stb = txb; rx_buf_closed_stb = rxb;
        reg_sel = wr; reg_wr = wr; reg_addr = adr; reg_wdata = wd;
        #1;
        exp_rd = adr ? m_en : m_evt;
        vectors++;
        if (reg_rdata !== exp_rd) begin
            misses++;
            $display("FAIL %s rdata addr=%0d: actual=%h expected=%h", tag, adr, reg_rdata, exp_rd);
        end
        vectors++;
        if (irq !== m_irq) begin
            misses++;
            $display("FAIL %s irq: actual=%b expected=%b", tag, irq, m_irq);
        end
        set_m = 8'h00;
        if (ss && !m_sel_prev && mm) set_m[5] = 1'b1;
        if (txe)         set_m[4] = 1'b1;
        if (rxc && !rxf) set_m[2] = 1'b1;
        if (txb)         set_m[1] = 1'b1;
        if (rxb)         set_m[0] = 1'b1;
        clr_m = (wr && !adr) ? wd : 8'h00;
        n_evt = ((m_evt & ~clr_m) | set_m) & 8'h37;
        n_en  = (wr && adr) ? (wd & 8'h37) : m_en;
        n_irq = |(m_evt & m_en);
        @(posedge clk);
        m_evt = n_evt; m_en = n_en; m_irq = n_irq; m_sel_prev = ss;
        @(negedge clk);
    endtask

    task automatic idle(input logic adr, input string tag);
        cyc(ss_active, master_mode, 0, 0, 0, 0, 0, 0, adr, 8'h00, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(0, "R1"); idle(1, "R1");
        // R10 enable register load, R2 reserved lines dropped
        cyc(0,0,0,0,0,0,0, 1,1, 8'hFF, "R10");
        idle(1, "R2"); idle(0, "R10");
        // R8 transmit buffer done, R11 request follows a cycle later
        cyc(0,0,0,0,0,1,0, 0,0, 8'h00, "R8");
        idle(0, "R11"); idle(0, "R11");
        // R3 zero write keeps, one write clears
        cyc(0,0,0,0,0,0,0, 1,0, 8'h00, "R3");
        idle(0, "R3");
        cyc(0,0,0,0,0,0,0, 1,0, 8'h02, "R3");
        idle(0, "R11"); idle(0, "R11");
        // R7 R6 R9 flags
        cyc(0,0,0,0,1,0,0, 0,0, 8'h00, "R7");
        cyc(0,0,1,1,0,0,0, 0,0, 8'h00, "R6");
        idle(0, "R6");
        cyc(0,0,1,0,0,0,0, 0,0, 8'h00, "R6");
        cyc(0,0,0,0,0,0,1, 0,0, 8'h00, "R9");
        idle(0, "R9");
        // R2 reserved lines written with ones change nothing
        cyc(0,0,0,0,0,0,0, 1,0, 8'hC8, "R2");
        idle(0, "R2");
        // R3 multi-clear
        cyc(0,0,0,0,0,0,0, 1,0, 8'h15, "R3");
        idle(0, "R3"); idle(0, "R11");
        // R5 collision: rise in master, held across clear, rise in slave
        cyc(1,1,0,0,0,0,0, 0,0, 8'h00, "R5");
        idle(0, "R5");
        cyc(1,1,0,0,0,0,0, 1,0, 8'h20, "R5");
        idle(0, "R5"); idle(0, "R5");
        cyc(0,1,0,0,0,0,0, 0,0, 8'h00, "R5");
        cyc(1,0,0,0,0,0,0, 0,0, 8'h00, "R5");
        idle(0, "R5");
        cyc(0,0,0,0,0,0,0, 0,0, 8'h00, "R5");
        // R4 set and clear of the same flag in one cycle
        cyc(0,0,0,0,0,1,0, 1,0, 8'h02, "R4");
        idle(0, "R4");
        // R11 partial enable: only TXB enabled, RXB pending but disabled
        cyc(0,0,0,0,0,0,0, 1,1, 8'h02, "R10");
        cyc(0,0,0,0,0,0,1, 0,0, 8'h00, "R11");
        idle(0, "R11");
        cyc(0,0,0,0,0,0,0, 1,0, 8'h02, "R11");
        idle(0, "R11"); idle(0, "R11"); idle(1, "R11");
        // R10 write needs select: reg_wr alone ignored
        reg_sel = 0; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h37;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
        idle(1, "R10");
        // R11 disabled event leaves irq low
        cyc(0,0,0,0,1,0,0, 0,0, 8'h00, "R11");
        idle(0, "R11"); idle(0, "R11");
        finish_run();
    end
endmodule